// File: doc/BRIEF.md
# Slow Byte-Memory Read Sequencer

This block lets a synchronous host read a byte-wide asynchronous read-only memory whose outputs have long nanosecond delays. The host raises a request with a 16-bit address. When the sequencer is ready, it takes the request, drives the address and pulls the active-low chip select low. It then waits a number of clock cycles before pulling the active-low output gate low. It captures the byte when every delay limit has run out and returns the byte with a one-cycle valid strobe.

The wait is not one fixed wait-state count. Each access uses three separate limits taken from a selectable speed grade: address-to-data, select-to-data and gate-to-data. Each limit is converted to whole clock cycles by ceiling division by the clock-period parameter, with a minimum of one cycle. The output gate is held back until it is no longer the critical path. After the capture the sequencer keeps the host waiting until the memory outputs have floated. The chip select goes back to standby unless the host already presents the next request. In that case the select stays low and only the address moves.

Top module: `eprom_rd_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, hostReady is 1, memCeN is 1, memOeN is 1 and hostValid is 0.
- R2: A request is taken on a clock edge where hostReq and hostReady are both 1. hostReady is 0 from that edge until the turnaround ends. While hostReady is 0, memAddr does not change and later changes of hostAddr have no effect.
- R3: memCeN goes low at the edge that takes a request. memOeN is low only while memCeN is low. memAddr is stable for as long as memOeN is low.
- R4: memOeN goes low L cycles after the accept edge, where L = max(1, ceil((tAcc - tOe) / CLK_NS)).
- R5: The byte on memData is captured W cycles after memOeN falls, where W = max(ceil(tOe/CLK_NS), ceil(tAcc/CLK_NS) - L). At 10 ns the total is 9, 12 or 15 cycles. hostValid is high for one cycle, in the cycle where memOeN returns high, and hostRdata holds the captured byte.
- R6: The grade code is 2'b00 for tAcc 90 / tOe 40 / tFloat 35 ns, 2'b01 for 120 / 50 / 25 ns, and 2'b10 or 2'b11 for 150 / 50 / 45 ns. The grade is sampled at the accept edge, and changing it later has no effect on that access.
- R7: hostReady returns ceil(tFloat/CLK_NS) cycles after the capture edge. The next fall of memOeN is at least tFloat of the previous access after its rise.
- R8: If hostReq is low at the capture edge, memCeN goes high at that edge. While idle with no request, memCeN stays high.
- R9: If hostReq is held high through the capture edge, memCeN stays low through the turnaround and into the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host read request |
| hostAddr | input | 16 | Host byte address |
| gradeSel | input | 2 | Speed grade of the memory |
| hostReady | output | 1 | Sequencer can take a request |
| hostRdata | output | 8 | Returned byte |
| hostValid | output | 1 | hostRdata valid, one cycle |
| memAddr | output | 16 | Address to the memory |
| memCeN | output | 1 | Active-low chip select |
| memOeN | output | 1 | Active-low output gate |
| memData | input | 8 | Data from the memory |

## Verification
The capture edge does two things in the same cycle. It samples the byte and releases the output gate, and it also decides whether the chip select goes to standby or stays low for a queued request. The bench provokes both outcomes. In one case it drops hostReq straight after the accept. In the other it holds hostReq through a burst of three reads. It judges each case by the data value, the latency and the level of memCeN at the valid cycle and at the end of the turnaround. The bench memory model returns a wrong byte whenever any of the three delay limits has not run out.

// File: rtl/eprom_seq_pkg.sv
`timescale 1ns/1ps
package eprom_seq_pkg;

  typedef struct packed {
    logic loadAddr;
    logic capture;
  } seq_strobe_t;

  function automatic int ns2cyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int pick3(input int idx, input int a, input int b, input int c);
    return (idx == 0) ? a : (idx == 1) ? b : c;
  endfunction

endpackage

// File: rtl/eprom_seq_ctrl.sv
`timescale 1ns/1ps
module eprom_seq_ctrl
  import eprom_seq_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int ACC_FAST_NS = 90,
  parameter int ACC_MID_NS  = 120,
  parameter int ACC_SLOW_NS = 150,
  parameter int OE_FAST_NS  = 40,
  parameter int OE_MID_NS   = 50,
  parameter int OE_SLOW_NS  = 50,
  parameter int DF_FAST_NS  = 35,
  parameter int DF_MID_NS   = 25,
  parameter int DF_SLOW_NS  = 45
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic [1:0]  gradeSel,
  output logic        hostReady,
  output logic        memCeN,
  output logic        memOeN,
  output seq_strobe_t strobe
);

  localparam int CNT_CAP = ns2cyc(ACC_FAST_NS + ACC_MID_NS + ACC_SLOW_NS
                                  + DF_FAST_NS + DF_MID_NS + DF_SLOW_NS, CLK_NS);
  localparam int CW = $clog2(CNT_CAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_OEWAIT, S_FLOAT} seq_state_e;

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [1:0]    gradeQ;
  logic [CW-1:0] leadTbl  [4];
  logic [CW-1:0] waitTbl  [4];
  logic [CW-1:0] floatTbl [4];

  // one row per grade code; code 3 reuses the slowest limits
  for (genvar g = 0; g < 4; g++) begin : g_grade
    localparam int SRC  = (g > 2) ? 2 : g;
    localparam int ACC  = pick3(SRC, ACC_FAST_NS, ACC_MID_NS, ACC_SLOW_NS);
    localparam int OE   = pick3(SRC, OE_FAST_NS, OE_MID_NS, OE_SLOW_NS);
    localparam int DF   = pick3(SRC, DF_FAST_NS, DF_MID_NS, DF_SLOW_NS);
    localparam int LEAD = ns2cyc(ACC - OE, CLK_NS);
    localparam int ACCC = ns2cyc(ACC, CLK_NS);
    localparam int OEC  = ns2cyc(OE, CLK_NS);
    localparam int WAIT = (OEC > ACCC - LEAD) ? OEC : (ACCC - LEAD);
    assign leadTbl[g]  = CW'(LEAD);
    assign waitTbl[g]  = CW'(WAIT);
    assign floatTbl[g] = CW'(ns2cyc(DF, CLK_NS));
  end

  logic accept;
  assign accept         = hostReq && (state == S_IDLE);
  assign hostReady      = (state == S_IDLE);
  assign strobe.loadAddr = accept;
  assign strobe.capture  = (state == S_OEWAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      gradeQ <= 2'd0;
      memCeN <= 1'b1;
      memOeN <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            memCeN <= 1'b0;
            gradeQ <= gradeSel;
            cnt    <= leadTbl[gradeSel] - 1'b1;
            state  <= S_LEAD;
          end else begin
            memCeN <= 1'b1;
          end
        end
        S_LEAD: begin
          if (cnt == '0) begin
            memOeN <= 1'b0;
            cnt    <= waitTbl[gradeQ] - 1'b1;
            state  <= S_OEWAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_OEWAIT: begin
          if (cnt == '0) begin
            memOeN <= 1'b1;
            memCeN <= ~hostReq;
            cnt    <= floatTbl[gradeQ] - 1'b1;
            state  <= S_FLOAT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (!hostReq) memCeN <= 1'b1;
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R2: no output gate while the sequencer offers to take a request
  a_r2_ready_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> memOeN);

  // R8: idle without a request leads to standby
  a_r8_idle_standby: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && !hostReq) |=> memCeN);

endmodule

// File: rtl/eprom_seq_dp.sv
`timescale 1ns/1ps
module eprom_seq_dp
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostValid
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      hostRdata <= '0;
      hostValid <= 1'b0;
    end else begin
      if (strobe.loadAddr) memAddr   <= hostAddr;
      if (strobe.capture)  hostRdata <= memData;
      hostValid <= strobe.capture;
    end
  end

  // R5: the valid strobe lasts exactly one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |=> !hostValid);

endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
  import eprom_seq_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        gradeSel,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  seq_strobe_t strobe;

  eprom_seq_ctrl #(.CLK_NS(CLK_NS)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .gradeSel(gradeSel),
    .hostReady(hostReady), .memCeN(memCeN), .memOeN(memOeN), .strobe(strobe)
  );

  eprom_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .memData(memData), .memAddr(memAddr), .hostRdata(hostRdata),
    .hostValid(hostValid)
  );

  // R3: output gate only inside chip select
  a_r3_gate_in_select: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  // R3: address held while the memory drives data
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |=> $stable(memAddr));

  // R2: no new address while busy
  a_r2_busy_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hostReady |=> $stable(memAddr));

  // R5: valid coincides with the release of the output gate
  a_r5_valid_at_release: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |-> $rose(memOeN));

endmodule

// File: tb/test_eprom_rd_seq.sv
`timescale 1ns/1ps
module test_eprom_rd_seq;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [1:0]  gradeSel = 2'b00;
  logic        hostReady, hostValid, memCeN, memOeN;
  logic [7:0]  hostRdata;
  logic [15:0] memAddr;
  logic [7:0]  memData = 8'h00;

  int nChk = 0;
  int nFail = 0;

  real curAcc = 150.0, curOe = 50.0, curDf = 45.0, lastDf = 0.0;
  real tAddr = 0.0, tCe = 0.0, tOe = 0.0, tOeRise = 0.0;

  eprom_rd_seq #(.CLK_NS(CLK_NS)) i_eprom_rd_seq (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostAddr(hostAddr),
    .gradeSel(gradeSel), .hostReady(hostReady), .hostRdata(hostRdata),
    .hostValid(hostValid), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memData(memData)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model: timestamps of pin changes
  always @(memAddr) tAddr = $realtime;
  always @(negedge memCeN) tCe = $realtime;
  always @(negedge memOeN) begin
    tOe = $realtime;
    check(($realtime - tOeRise) >= lastDf, "R7 float before reuse",
          int'($realtime - tOeRise), int'(lastDf));
  end
  always @(posedge memOeN) begin
    tOeRise = $realtime;
    lastDf  = curDf;
  end

  // evaluated half a nanosecond before every integer time, so before each edge
  initial begin
    #0.5;
    forever begin
      real now;
      bit good;
      now  = $realtime + 0.5;
      good = !memCeN && !memOeN && (now - tAddr >= curAcc) &&
             (now - tCe >= curAcc) && (now - tOe >= curOe);
      memData = good ? romByte(memAddr) : ~romByte(memAddr);
      #1;
    end
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  task automatic run_access(input logic [15:0] a, input logic [1:0] g,
                            input bit holdReq, input bit swapGrade);
    int accNs, oeNs, dfNs, lead, wt, total, fl, n, oeAt, k;
    accNs = (g == 2'b00) ? 90 : (g == 2'b01) ? 120 : 150;
    oeNs  = (g == 2'b00) ? 40 : 50;
    dfNs  = (g == 2'b00) ? 35 : (g == 2'b01) ? 25 : 45;
    lead  = cyc(accNs - oeNs);
    wt    = (cyc(oeNs) > cyc(accNs) - lead) ? cyc(oeNs) : cyc(accNs) - lead;
    total = lead + wt;
    fl    = cyc(dfNs);
    while (!hostReady) @(negedge clk);
    curAcc = accNs; curOe = oeNs; curDf = dfNs;
    hostAddr = a; gradeSel = g; hostReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n = 1; oeAt = 0;
    check(hostReady == 1'b0, "R2 busy after accept", hostReady, 0);
    check(memCeN == 1'b0, "R3 select low after accept", memCeN, 0);
    hostAddr = ~a;
    if (!holdReq) hostReq = 1'b0;
    if (swapGrade) gradeSel = 2'b00;
    while (!hostValid && n < 100) begin
      @(negedge clk);
      n++;
      if (!memOeN && oeAt == 0) oeAt = n;
    end
    check(oeAt - 1 == lead, "R4 gate delay", oeAt - 1, lead);
    check(n - 1 == total, swapGrade ? "R6 latched grade latency" : "R5 latency",
          n - 1, total);
    check(hostRdata == romByte(a), "R5 data", hostRdata, romByte(a));
    check(memOeN == 1'b1, "R5 gate released at valid", memOeN, 1);
    if (holdReq)
      check(memCeN == 1'b0, "R9 select kept low", memCeN, 0);
    else
      check(memCeN == 1'b1, "R8 standby after capture", memCeN, 1);
    k = 0;
    while (!hostReady && k < 100) begin
      @(negedge clk);
      k++;
      check(hostValid == 1'b0, "R5 single valid", hostValid, 0);
    end
    check(k == fl, "R7 turnaround", k, fl);
    if (holdReq) check(memCeN == 1'b0, "R9 select low at ready", memCeN, 0);
  endtask

  task automatic reset_test();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hostReady && memCeN && memOeN && !hostValid, "R1 reset state",
          {hostReady, memCeN, memOeN, hostValid}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady && memCeN && memOeN && !hostValid, "R1 after release",
          {hostReady, memCeN, memOeN, hostValid}, 4'b1110);
  endtask

  task automatic idle_test();
    hostReq = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(memCeN == 1'b1 && hostReady && !hostValid, "R8 idle standby",
            {memCeN, hostReady, hostValid}, 3'b110);
    end
  endtask

  task automatic burst_test();
    run_access(16'h1234, 2'b01, 1'b1, 1'b0);
    run_access(16'hBEEF, 2'b00, 1'b1, 1'b0);
    run_access(16'h0F0F, 2'b10, 1'b0, 1'b0);
  endtask

  initial begin
    reset_test();
    idle_test();
    run_access(16'h0000, 2'b00, 1'b0, 1'b0);
    run_access(16'hFFFF, 2'b01, 1'b0, 1'b0);
    run_access(16'hA55A, 2'b10, 1'b0, 1'b0);
    run_access(16'h8001, 2'b11, 1'b0, 1'b0);
    run_access(16'h7E42, 2'b10, 1'b0, 1'b1);
    burst_test();
    idle_test();
    finish_up();
  end

endmodule